// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block keeps the interrupt state of a packet network controller: an 8-bit status register, an 8-bit enable mask and one level-sensitive interrupt line toward the host. Event strobes from the surrounding controller set individual status bits. The host clears bits by writing an acknowledge value to the status offset of a small byte register bus. Only a fixed subset of the bits can be cleared this way. Two bits are kept up to date from the occupancy of the transmit queue and of the transmit completion queue. The receive bit follows the receive queue whenever an entry is popped from it.

Acknowledging the transmit-done bit also sends a pop request to the external completion queue. That request is asserted in the same cycle as the acknowledge write, so the queue drops its head on the same clock edge that clears the bit. The next update then sees the queue's new occupancy and does not re-raise the bit from stale state.

Top module: `isr_unit`

## Requirements
- R1: After reset the status register reads 0x04 (only the transmit-empty bit set), the mask reads 0x00 and `irq` is low.
- R2: Status bit positions: 0 receive, 1 transmit done, 2 transmit queue empty, 3 allocation done, 4 receive overrun, 5 PHY event, 6 early receive, 7 management. A high `evt_set[i]` in a cycle sets bit i at the next clock edge.
- R3: A bus write to offset 0 (acknowledge) clears exactly the status bits selected by the written byte ANDed with 0xD6. Bits 0, 3 and 5 are never changed by an acknowledge.
- R4: `done_pop` is high during every cycle that carries an acknowledge write with data bit 1 set, and low in every other cycle.
- R5: In every cycle in which `tx_empty` is high, status bit 2 is set at the next edge. This overrides an acknowledge of bit 2 in that cycle. The queue state never clears the bit.
- R6: In every cycle in which `done_nonempty` is high and no acknowledge of bit 1 is written, status bit 1 is set at the next edge. In the acknowledge cycle the bit is cleared, and later cycles see the queue's post-pop occupancy.
- R7: When `rx_pop` is high, status bit 0 takes the value of `rx_left` (1 if receive entries remain after the pop, 0 if the pop emptied the queue).
- R8: When an event strobe and a clearing action (acknowledge or emptying receive pop) hit the same bit in the same cycle, the bit ends up set.
- R9: `irq` is high exactly when (status AND mask) is non-zero. It follows register changes in the cycle they take effect.
- R10: Offset 1 is the mask: a write loads it and a read returns it. A read of offset 0 returns the status. Reads of other offsets return 0x00. Writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register byte offset |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational by default) |
| evt_set | input | 8 | Per-bit event strobes that set status bits |
| rx_pop | input | 1 | Receive queue head removed this cycle |
| rx_left | input | 1 | Receive queue still holds entries after this pop |
| tx_empty | input | 1 | Transmit queue length is zero |
| done_nonempty | input | 1 | Transmit completion queue holds at least one entry |
| done_pop | output | 1 | Pop request to the completion queue |
| irq | output | 1 | Level interrupt: masked status is non-zero |

## Verification
The properties assume that `done_nonempty` and `tx_empty` report the queues as they are at each edge. They also assume that the completion queue removes its head on the edge where `done_pop` is high, so the occupancy seen in the following cycle is already the post-pop value. The stimulus changes every input only at the falling clock edge. It lowers `done_nonempty` in the cycle right after an acknowledge that emptied a one-entry completion queue, and keeps it high when entries remain. Each scenario starts from a fresh reset, because bits 3 and 5 are cleared only by reset.

// File: rtl/isr_pkg.sv
package isr_pkg;
   localparam int unsigned ISR_W_DEF  = 8;
   localparam int unsigned ISR_AW_DEF = 2;

   // Bit roles inside the status byte
   localparam int unsigned BIT_RX      = 0;
   localparam int unsigned BIT_TXDONE  = 1;
   localparam int unsigned BIT_TXEMPTY = 2;

   localparam logic [ISR_W_DEF-1:0] ACK_MASK_DEF  = 8'hD6;
   localparam logic [ISR_W_DEF-1:0] RESET_ST_DEF  = 8'h04;

   typedef enum logic [ISR_AW_DEF-1:0] {
      OFS_STATUS = 2'd0,
      OFS_MASK   = 2'd1
   } isr_ofs_e;
endpackage

// File: rtl/isr_status_bank.sv
module isr_status_bank #(
   parameter int unsigned W           = 8,
   parameter logic [W-1:0] ACK_MASK   = 'hD6,
   parameter logic [W-1:0] RESET_VAL  = 'h04,
   parameter int unsigned RX_BIT      = 0,
   parameter int unsigned TXDONE_BIT  = 1,
   parameter int unsigned TXEMPTY_BIT = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_set,
   input  logic         ack_we,
   input  logic [W-1:0] ack_val,
   input  logic         rx_pop,
   input  logic         rx_left,
   input  logic         tx_empty,
   input  logic         done_nonempty,
   output logic [W-1:0] status_q
);
   localparam logic [W-1:0] CLR_SEL = ACK_MASK;

   logic ack_done;
   assign ack_done = ack_we && ack_val[TXDONE_BIT];

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic regen;
      logic pop_hit;
      logic pop_val;
      logic ack_hit;
      logic nxt;

      if (CLR_SEL[i]) begin : g_ack
         assign ack_hit = ack_we && ack_val[i];
      end else begin : g_noack
         assign ack_hit = 1'b0;
      end

      if (i == RX_BIT) begin : g_rx
         assign pop_hit = rx_pop;
         assign pop_val = rx_left;
      end else begin : g_norx
         assign pop_hit = 1'b0;
         assign pop_val = 1'b0;
      end

      if (i == TXEMPTY_BIT) begin : g_txe
         assign regen = tx_empty;
      end else if (i == TXDONE_BIT) begin : g_txd
         // Queue head leaves on this edge: occupancy seen now is stale
         assign regen = done_nonempty && !ack_done;
      end else begin : g_noregen
         assign regen = 1'b0;
      end

      always_comb begin
         nxt = status_q[i];
         if (ack_hit) nxt = 1'b0;
         if (pop_hit) nxt = pop_val;
         if (regen)   nxt = 1'b1;
         if (evt_set[i]) nxt = 1'b1;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) status_q[i] <= RESET_VAL[i];
         else        status_q[i] <= nxt;
      end
   end
endmodule

// File: rtl/isr_mask_reg.sv
module isr_mask_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mask_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  mask_q <= '0;
      else if (we) mask_q <= wdata;
   end
endmodule

// File: rtl/isr_read_mux.sv
module isr_read_mux #(
   parameter int unsigned W        = 8,
   parameter int unsigned AW       = 2,
   parameter int unsigned STAT_OFS = 0,
   parameter int unsigned MASK_OFS = 1
) (
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  status,
   input  logic [W-1:0]  mask,
   output logic [W-1:0]  rdata
);
   localparam logic [AW-1:0] A_ST = AW'(STAT_OFS);
   localparam logic [AW-1:0] A_MK = AW'(MASK_OFS);

   always_comb begin
      if (addr == A_ST)      rdata = status;
      else if (addr == A_MK) rdata = mask;
      else                   rdata = '0;
   end
endmodule

// File: rtl/isr_unit.sv
module isr_unit
   import isr_pkg::*;
#(
   parameter int unsigned W           = ISR_W_DEF,
   parameter int unsigned AW          = ISR_AW_DEF,
   parameter int unsigned STAT_OFS    = 0,
   parameter int unsigned MASK_OFS    = 1,
   parameter logic [W-1:0] ACK_MASK   = ACK_MASK_DEF,
   parameter logic [W-1:0] RESET_ST   = RESET_ST_DEF,
   parameter int unsigned RX_BIT      = BIT_RX,
   parameter int unsigned TXDONE_BIT  = BIT_TXDONE,
   parameter int unsigned TXEMPTY_BIT = BIT_TXEMPTY,
   parameter bit          RD_REG      = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_we,
   input  logic [W-1:0]  bus_wdata,
   output logic [W-1:0]  bus_rdata,
   input  logic [W-1:0]  evt_set,
   input  logic          rx_pop,
   input  logic          rx_left,
   input  logic          tx_empty,
   input  logic          done_nonempty,
   output logic          done_pop,
   output logic          irq
);
   localparam logic [AW-1:0] A_ST = AW'(STAT_OFS);
   localparam logic [AW-1:0] A_MK = AW'(MASK_OFS);

   // Elaboration checks on the parameter set
   if (RX_BIT >= W || TXDONE_BIT >= W || TXEMPTY_BIT >= W) begin : g_bad_bit
      $error("isr_unit: role bit index outside status width");
   end
   if (RX_BIT == TXDONE_BIT || RX_BIT == TXEMPTY_BIT || TXDONE_BIT == TXEMPTY_BIT) begin : g_bad_role
      $error("isr_unit: role bits must be distinct");
   end
   if (STAT_OFS == MASK_OFS || STAT_OFS >= (1 << AW) || MASK_OFS >= (1 << AW)) begin : g_bad_ofs
      $error("isr_unit: register offsets clash or exceed address space");
   end

   logic [W-1:0] status_q;
   logic [W-1:0] mask_q;
   logic [W-1:0] rd_comb;
   logic         ack_we;
   logic         mask_we;

   assign ack_we  = bus_we && (bus_addr == A_ST);
   assign mask_we = bus_we && (bus_addr == A_MK);

   isr_status_bank #(
      .W(W), .ACK_MASK(ACK_MASK), .RESET_VAL(RESET_ST),
      .RX_BIT(RX_BIT), .TXDONE_BIT(TXDONE_BIT), .TXEMPTY_BIT(TXEMPTY_BIT)
   ) u_status (
      .clk(clk), .rst_n(rst_n), .evt_set(evt_set),
      .ack_we(ack_we), .ack_val(bus_wdata),
      .rx_pop(rx_pop), .rx_left(rx_left),
      .tx_empty(tx_empty), .done_nonempty(done_nonempty),
      .status_q(status_q)
   );

   isr_mask_reg #(.W(W)) u_mask (
      .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(bus_wdata), .mask_q(mask_q)
   );

   isr_read_mux #(.W(W), .AW(AW), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)) u_rmux (
      .addr(bus_addr), .status(status_q), .mask(mask_q), .rdata(rd_comb)
   );

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) bus_rdata <= '0;
         else        bus_rdata <= rd_comb;
      end
   end else begin : g_rd_comb
      assign bus_rdata = rd_comb;
   end

   assign done_pop = ack_we && bus_wdata[TXDONE_BIT];
   assign irq      = |(status_q & mask_q);
endmodule

// File: rtl/isr_unit_chk.sv
module isr_unit_chk #(
   parameter int unsigned W           = 8,
   parameter int unsigned AW          = 2,
   parameter int unsigned STAT_OFS    = 0,
   parameter logic [W-1:0] ACK_MASK   = 'hD6,
   parameter logic [W-1:0] RESET_ST   = 'h04,
   parameter int unsigned RX_BIT      = 0,
   parameter int unsigned TXDONE_BIT  = 1,
   parameter int unsigned TXEMPTY_BIT = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] bus_addr,
   input logic          bus_we,
   input logic [W-1:0]  bus_wdata,
   input logic [W-1:0]  evt_set,
   input logic          rx_pop,
   input logic          rx_left,
   input logic          tx_empty,
   input logic          done_nonempty,
   input logic          done_pop,
   input logic          irq,
   input logic [W-1:0]  status_q,
   input logic [W-1:0]  mask_q
);
   logic ack_wr;
   assign ack_wr = bus_we && (bus_addr == AW'(STAT_OFS));

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (status_q == RESET_ST && mask_q == '0 && !irq));

   assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_set != '0) |=> ((status_q & $past(evt_set)) == $past(evt_set)));

   assert_pop_empties_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_pop && !evt_set[TXDONE_BIT]) |=> !status_q[TXDONE_BIT]);

   assert_txempty_regen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |=> status_q[TXEMPTY_BIT]);

   assert_done_regen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_nonempty && !done_pop) |=> status_q[TXDONE_BIT]);

   assert_rx_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && !evt_set[RX_BIT]) |=> (status_q[RX_BIT] == $past(rx_left)));

   assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq);

   for (genvar i = 0; i < W; i++) begin : g_bits
      if (ACK_MASK[i] && i != TXDONE_BIT && i != TXEMPTY_BIT) begin : g_clr
         assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_wr && bus_wdata[i] && !evt_set[i]) |=> !status_q[i]);
      end
      if (!ACK_MASK[i] && i != RX_BIT) begin : g_keep
         assert_unackable_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
            status_q[i] |=> status_q[i]);
      end
      if (ACK_MASK[i]) begin : g_prio
         assert_set_beats_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_wr && bus_wdata[i] && evt_set[i]) |=> status_q[i]);
      end
   end
endmodule

bind isr_unit isr_unit_chk #(
   .W(W), .AW(AW), .STAT_OFS(STAT_OFS), .ACK_MASK(ACK_MASK), .RESET_ST(RESET_ST),
   .RX_BIT(RX_BIT), .TXDONE_BIT(TXDONE_BIT), .TXEMPTY_BIT(TXEMPTY_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .evt_set(evt_set), .rx_pop(rx_pop), .rx_left(rx_left),
   .tx_empty(tx_empty), .done_nonempty(done_nonempty), .done_pop(done_pop),
   .irq(irq), .status_q(status_q), .mask_q(mask_q)
);

// File: tb/isr_unit_tb.sv
`timescale 1ns/1ps
module isr_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] evt_set = '0;
   logic       rx_pop = 1'b0;
   logic       rx_left = 1'b0;
   logic       tx_empty = 1'b0;
   logic       done_nonempty = 1'b0;
   logic       done_pop;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   isr_unit u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
      .rx_pop(rx_pop), .rx_left(rx_left), .tx_empty(tx_empty),
      .done_nonempty(done_nonempty), .done_pop(done_pop), .irq(irq)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bus_we = 1'b0; evt_set = '0; rx_pop = 1'b0; rx_left = 1'b0;
      tx_empty = 1'b0; done_nonempty = 1'b0; bus_addr = '0; bus_wdata = '0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse_evt(input logic [7:0] e);
      @(negedge clk);
      evt_set = e;
      @(negedge clk);
      evt_set = '0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      do_reset();
      bus_read(2'd0, v); check("R1", "status after reset", v, 8'h04);
      bus_read(2'd1, v); check("R1", "mask after reset", v, 8'h00);
      check("R1", "irq after reset", irq, 0);
   endtask

   task automatic t_events_ack();
      logic [7:0] v;
      do_reset();
      pulse_evt(8'hF8);
      bus_read(2'd0, v); check("R2", "status after events 7..3", v, 8'hFC);
      bus_write(2'd0, 8'hFF);
      bus_read(2'd0, v); check("R3", "ack all leaves 3,5", v, 8'h28);
      pulse_evt(8'h03);
      bus_read(2'd0, v); check("R2", "events 1,0 set", v, 8'h2B);
      bus_write(2'd0, 8'h29);
      bus_read(2'd0, v); check("R3", "ack of 0,3,5 ignored", v, 8'h2B);
      bus_write(2'd0, 8'h02);
      bus_read(2'd0, v); check("R3", "ack of bit 1 clears it", v, 8'h29);
   endtask

   task automatic t_mask_irq();
      logic [7:0] v;
      do_reset();
      bus_write(2'd1, 8'h10);
      #1 check("R9", "irq with unmasked bits clear", irq, 0);
      pulse_evt(8'h10);
      #1 check("R9", "irq after overrun event", irq, 1);
      bus_write(2'd0, 8'h10);
      #1 check("R9", "irq after ack", irq, 0);
      bus_write(2'd1, 8'h04);
      #1 check("R9", "irq from reset tx-empty bit", irq, 1);
      bus_read(2'd1, v); check("R10", "mask readback", v, 8'h04);
      bus_write(2'd2, 8'hFF);
      bus_read(2'd2, v); check("R10", "unused offset reads zero", v, 8'h00);
      bus_read(2'd1, v); check("R10", "unused offset write ignored", v, 8'h04);
   endtask

   task automatic t_done_pop();
      logic [7:0] v;
      do_reset();
      bus_write(2'd0, 8'h04);
      @(negedge clk); done_nonempty = 1'b1;
      #1 check("R4", "no pop without write", done_pop, 0);
      @(negedge clk);
      bus_read(2'd0, v); check("R6", "completion queue raises bit 1", v, 8'h02);
      bus_addr = 2'd0; bus_wdata = 8'h02; bus_we = 1'b1;
      #1 check("R4", "pop during ack of bit 1", done_pop, 1);
      @(negedge clk); bus_we = 1'b0; done_nonempty = 1'b0;
      #1 check("R4", "pop lasts one cycle", done_pop, 0);
      bus_read(2'd0, v); check("R6", "ack of last entry clears bit 1", v, 8'h00);
      @(negedge clk); done_nonempty = 1'b1;
      @(negedge clk);
      bus_addr = 2'd0; bus_wdata = 8'h02; bus_we = 1'b1;
      @(negedge clk); bus_we = 1'b0;
      @(negedge clk);
      bus_read(2'd0, v); check("R6", "entries remain re-raise bit 1", v, 8'h02);
      done_nonempty = 1'b0;
      @(negedge clk); bus_addr = 2'd0; bus_wdata = 8'hFD; bus_we = 1'b1;
      #1 check("R4", "no pop when data bit 1 clear", done_pop, 0);
      @(negedge clk); bus_we = 1'b0;
   endtask

   task automatic t_tx_empty();
      logic [7:0] v;
      do_reset();
      bus_write(2'd0, 8'h04);
      bus_read(2'd0, v); check("R3", "ack of bit 2 with queue busy", v, 8'h00);
      @(negedge clk); tx_empty = 1'b1;
      @(negedge clk); tx_empty = 1'b0;
      bus_read(2'd0, v); check("R5", "empty queue raises bit 2", v, 8'h04);
      @(negedge clk); tx_empty = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h04; bus_we = 1'b1;
      @(negedge clk); bus_we = 1'b0; tx_empty = 1'b0;
      bus_read(2'd0, v); check("R5", "empty queue overrides ack", v, 8'h04);
   endtask

   task automatic t_rx_pop();
      logic [7:0] v;
      do_reset();
      pulse_evt(8'h01);
      @(negedge clk); rx_pop = 1'b1; rx_left = 1'b1;
      @(negedge clk); rx_pop = 1'b0; rx_left = 1'b0;
      bus_read(2'd0, v); check("R7", "pop with entries left", v, 8'h05);
      @(negedge clk); rx_pop = 1'b1; rx_left = 1'b0;
      @(negedge clk); rx_pop = 1'b0;
      bus_read(2'd0, v); check("R7", "pop that empties queue", v, 8'h04);
      @(negedge clk); rx_pop = 1'b1; rx_left = 1'b1;
      @(negedge clk); rx_pop = 1'b0; rx_left = 1'b0;
      bus_read(2'd0, v); check("R7", "pop leaving entries sets bit 0", v, 8'h05);
   endtask

   task automatic t_priority();
      logic [7:0] v;
      do_reset();
      pulse_evt(8'h80);
      @(negedge clk); evt_set = 8'h80; bus_addr = 2'd0; bus_wdata = 8'h80; bus_we = 1'b1;
      @(negedge clk); evt_set = '0; bus_we = 1'b0;
      bus_read(2'd0, v); check("R8", "event beats ack", v, 8'h84);
      @(negedge clk); evt_set = 8'h01; rx_pop = 1'b1; rx_left = 1'b0;
      @(negedge clk); evt_set = '0; rx_pop = 1'b0;
      bus_read(2'd0, v); check("R8", "event beats emptying pop", v, 8'h85);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL R1 watchdog: actual=timeout expected=completion");
         summary();
      end
   end

   initial begin
      t_reset();
      t_events_ack();
      t_mask_irq();
      t_done_pop();
      t_tx_empty();
      t_rx_pop();
      t_priority();
      finished = 1'b1;
      summary();
   end
endmodule